// File: doc/BRIEF.md
# Microcoded Register Datapath Executor

This block executes one 36-bit horizontal control word on every clock. It holds a set of 32-bit working registers for a stack-oriented machine and an 8-bit byte buffer. Each word picks one register for the B operand bus. It picks an A operand, which is either the H register or a small constant. An ALU and a shifter combine the two. The result drives the C bus, where any subset of nine destination registers may capture it on the same edge. The same word can also start a word read at the memory address register, or a byte fetch at the program counter.

A sequencer outside the block supplies the control words and reads back the next control-store address, which is taken from each word's next-address field. Memory sits outside the block. It answers a strobe in the cycle that the strobe is visible, and the block captures the answer at the end of that cycle. The last C-bus result is exposed on a registered port, so every register can be inspected by routing it through the ALU.

Top module: `ucode_datapath`

## Requirements
- R1: Synchronous active-high reset clears every register, the byte buffer and all outputs (`next_addr`, `cbus_q`, both strobes and both addresses) to zero.
- R2: After each word, `next_addr` holds that word's bits [35:27]. The jump field in bits [26:24] has no effect on any output.
- R3: The B-select field in bits [3:0] maps codes 0 to 8 to MDR, PC, MBR-signed, MBR-unsigned, SP, LV, CPP, TOS and OPC. Codes 9 to 15 put zero on the B bus.
- R4: Code 2 presents the byte buffer sign-extended to 32 bits. Code 3 presents it zero-extended.
- R5: The A-select field in bits [21:20] gives H for 0, zero for 1, +1 for 2 and all-ones (−1) for 3. No other register reaches the A input.
- R6: The operation field in bits [19:17] gives: 0 A+B, 1 B−A, 2 A&B, 3 A|B, 4 B, 5 A, 6 A+B+1, 7 ~B.
- R7: The shift field in bits [23:22] gives: 0 or 3 unshifted, 1 left by 8, 2 arithmetic right by 1. The shift is applied to the ALU result.
- R8: C-mask bits [15:7] enable, from bit 7 upward, MAR, MDR, PC, SP, LV, CPP, TOS, OPC and H. All enabled registers take the same result on one edge, and registers that are not enabled keep their value. `cbus_q` shows the result every cycle.
- R9: Read bit 5 raises `rd_req` in the following cycle. `rd_addr` then holds MAR as it was before that word's own writes. `rd_data` loads MDR at the end of the strobe cycle and wins over a C-bus write to MDR on that same edge.
- R10: Fetch bit 4 raises `fetch_req` in the following cycle. `fetch_addr` then holds PC as it was before that word's writes. `fetch_byte` loads the byte buffer at the end of the strobe cycle.
- R11: Write bit 6 raises no strobe and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| uinstr | input | 36 | Control word executed this cycle |
| rd_data | input | 32 | Word returned for a read strobe |
| fetch_byte | input | 8 | Byte returned for a fetch strobe |
| next_addr | output | 9 | Registered next control-store address |
| cbus_q | output | 32 | Registered C-bus result of the last word |
| rd_req | output | 1 | Word read strobe |
| rd_addr | output | 32 | Word read address (MAR) |
| fetch_req | output | 1 | Byte fetch strobe |
| fetch_addr | output | 32 | Byte fetch address (PC) |

## Verification
The hardest case to reach is the collision on MDR. A read answer and a C-bus write to MDR must land on the same edge. Getting there takes one word that only reads, then a second word that targets MDR from the C bus while the strobe of the first word is still out. The bench then routes MDR through the ALU to see which value was kept. A similar pairing puts a read or fetch in the same word that rewrites MAR or PC, which shows that the strobe address is the value from before the write.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  typedef enum logic [1:0] {
    ASEL_H    = 2'd0,
    ASEL_ZERO = 2'd1,
    ASEL_ONE  = 2'd2,
    ASEL_MONE = 2'd3
  } asel_e;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_PASSB = 3'd4,
    OP_PASSA = 3'd5,
    OP_ADD1  = 3'd6,
    OP_NOTB  = 3'd7
  } aluop_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_SLL8 = 2'd1,
    SH_SRA1 = 2'd2,
    SH_RSVD = 2'd3
  } shift_e;

  typedef struct packed {
    shift_e shift;
    asel_e  asel;
    aluop_e op;
    logic   spare;
  } aluctl_t;

  // B-bus source codes
  localparam int B_MDR  = 0;
  localparam int B_PC   = 1;
  localparam int B_MBRS = 2;
  localparam int B_MBRU = 3;
  localparam int B_SP   = 4;
  localparam int B_LV   = 5;
  localparam int B_CPP  = 6;
  localparam int B_TOS  = 7;
  localparam int B_OPC  = 8;
  localparam int NUM_BSRC = 9;

  // C-bus destination indices (bit order of the write mask)
  localparam int C_MAR = 0;
  localparam int C_MDR = 1;
  localparam int C_PC  = 2;
  localparam int C_SP  = 3;
  localparam int C_LV  = 4;
  localparam int C_CPP = 5;
  localparam int C_TOS = 6;
  localparam int C_OPC = 7;
  localparam int C_H   = 8;
  localparam int NUM_CDST = 9;

  localparam int BSEL_W = 4;
  localparam int MEM_W  = 3;
  localparam int ALU_W  = 8;
  localparam int JMP_W  = 3;

endpackage

// File: rtl/ucode_alu.sv
module ucode_alu
  import ucode_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SHIFT_BY = 8
) (
  input  aluctl_t       ctl,
  input  logic [DW-1:0] h_in,
  input  logic [DW-1:0] b_in,
  output logic [DW-1:0] y
);

  logic [DW-1:0] a_op;
  logic [DW-1:0] res;
  logic          unused_spare;

  assign unused_spare = ctl.spare;

  // A side: H or one of three constants
  always_comb begin
    unique case (ctl.asel)
      ASEL_H:    a_op = h_in;
      ASEL_ZERO: a_op = '0;
      ASEL_ONE:  a_op = DW'(1);
      default:   a_op = '1;
    endcase
  end

  always_comb begin
    unique case (ctl.op)
      OP_ADD:   res = a_op + b_in;
      OP_SUB:   res = b_in - a_op;
      OP_AND:   res = a_op & b_in;
      OP_OR:    res = a_op | b_in;
      OP_PASSB: res = b_in;
      OP_PASSA: res = a_op;
      OP_ADD1:  res = a_op + b_in + DW'(1);
      default:  res = ~b_in;
    endcase
  end

  always_comb begin
    unique case (ctl.shift)
      SH_SLL8: y = res << SHIFT_BY;
      SH_SRA1: y = $signed(res) >>> 1;
      default: y = res;
    endcase
  end

endmodule

// File: rtl/ucode_bsel.sv
module ucode_bsel
  import ucode_pkg::*;
#(
  parameter int DW    = 32,
  parameter int MBR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BSEL_W-1:0]            code,
  input  logic [NUM_CDST-1:0][DW-1:0]  regs,
  input  logic [MBR_W-1:0]             mbr,
  output logic [DW-1:0]                bbus
);

  logic [NUM_BSRC-1:0][DW-1:0] src;
  logic [NUM_BSRC-1:0]         sel;
  logic [NUM_BSRC-1:0][DW-1:0] gated;

  assign src[B_MDR]  = regs[C_MDR];
  assign src[B_PC]   = regs[C_PC];
  assign src[B_MBRS] = {{(DW-MBR_W){mbr[MBR_W-1]}}, mbr};
  assign src[B_MBRU] = {{(DW-MBR_W){1'b0}}, mbr};
  assign src[B_SP]   = regs[C_SP];
  assign src[B_LV]   = regs[C_LV];
  assign src[B_CPP]  = regs[C_CPP];
  assign src[B_TOS]  = regs[C_TOS];
  assign src[B_OPC]  = regs[C_OPC];

  // One decoded gate per source; the bus is the OR of gated sources
  for (genvar i = 0; i < NUM_BSRC; i++) begin : g_gate
    assign sel[i]   = (code == BSEL_W'(i));
    assign gated[i] = src[i] & {DW{sel[i]}};
  end

  always_comb begin
    bbus = '0;
    for (int i = 0; i < NUM_BSRC; i++) bbus = bbus | gated[i];
  end

  // R3: never more than one driver on the B bus
  assert_single_driver_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R3: unassigned codes leave the bus at zero
  assert_spare_code_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (code >= BSEL_W'(NUM_BSRC)) |-> (bbus == '0));

endmodule

// File: rtl/ucode_regfile.sv
module ucode_regfile
  import ucode_pkg::*;
#(
  parameter int DW    = 32,
  parameter int MBR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_CDST-1:0]          we,
  input  logic [DW-1:0]                cdata,
  input  logic                         rd_pend,
  input  logic [DW-1:0]                rd_data,
  input  logic                         fe_pend,
  input  logic [MBR_W-1:0]             fe_byte,
  output logic [NUM_CDST-1:0][DW-1:0]  q,
  output logic [MBR_W-1:0]             mbr
);

  for (genvar i = 0; i < NUM_CDST; i++) begin : g_reg
    if (i == C_MDR) begin : g_mem_loaded
      always_ff @(posedge clk) begin
        if (rst)          q[i] <= '0;
        else if (rd_pend) q[i] <= rd_data;
        else if (we[i])   q[i] <= cdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= '0;
        else if (we[i]) q[i] <= cdata;
      end

      // R8: a register left out of the mask holds its value
      assert_hold_unmasked_R8: assert property (@(posedge clk) disable iff (rst)
        !we[i] |=> $stable(q[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          mbr <= '0;
    else if (fe_pend) mbr <= fe_byte;
  end

  // R9: a returning read word beats the C bus into MDR
  assert_read_wins_mdr_R9: assert property (@(posedge clk) disable iff (rst)
    rd_pend |=> (q[C_MDR] == $past(rd_data)));

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import ucode_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NA_W  = 9,
  parameter int MBR_W = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NA_W+JMP_W+ALU_W+NUM_CDST+MEM_W+BSEL_W-1:0] uinstr,
  input  logic [DW-1:0]                                 rd_data,
  input  logic [MBR_W-1:0]                              fetch_byte,
  output logic [NA_W-1:0]                               next_addr,
  output logic [DW-1:0]                                 cbus_q,
  output logic                                          rd_req,
  output logic [DW-1:0]                                 rd_addr,
  output logic                                          fetch_req,
  output logic [DW-1:0]                                 fetch_addr
);

  localparam int BSEL_LO = 0;
  localparam int MEM_LO  = BSEL_LO + BSEL_W;
  localparam int CM_LO   = MEM_LO + MEM_W;
  localparam int ALU_LO  = CM_LO + NUM_CDST;
  localparam int JMP_LO  = ALU_LO + ALU_W;
  localparam int NA_LO   = JMP_LO + JMP_W;

  logic [BSEL_W-1:0]           f_bsel;
  logic                        f_wr, f_rd, f_fe;
  logic [NUM_CDST-1:0]         f_cmask;
  aluctl_t                     f_alu;
  logic [JMP_W-1:0]            f_jmp;
  logic [NA_W-1:0]             f_next;
  logic                        unused_fields;

  assign f_bsel  = uinstr[BSEL_LO +: BSEL_W];
  assign f_fe    = uinstr[MEM_LO];
  assign f_rd    = uinstr[MEM_LO + 1];
  assign f_wr    = uinstr[MEM_LO + 2];
  assign f_cmask = uinstr[CM_LO +: NUM_CDST];
  assign f_alu   = aluctl_t'(uinstr[ALU_LO +: ALU_W]);
  assign f_jmp   = uinstr[JMP_LO +: JMP_W];
  assign f_next  = uinstr[NA_LO +: NA_W];

  // Jump control and memory write are carried but not acted on
  assign unused_fields = ^{f_jmp, f_wr};

  logic [NUM_CDST-1:0][DW-1:0] regs;
  logic [MBR_W-1:0]            mbr;
  logic [DW-1:0]               bbus;
  logic [DW-1:0]               cbus;

  ucode_bsel #(.DW(DW), .MBR_W(MBR_W)) u_bsel (
    .clk  (clk),
    .rst  (rst),
    .code (f_bsel),
    .regs (regs),
    .mbr  (mbr),
    .bbus (bbus)
  );

  ucode_alu #(.DW(DW), .SHIFT_BY(MBR_W)) u_alu (
    .ctl  (f_alu),
    .h_in (regs[C_H]),
    .b_in (bbus),
    .y    (cbus)
  );

  ucode_regfile #(.DW(DW), .MBR_W(MBR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (f_cmask),
    .cdata   (cbus),
    .rd_pend (rd_req),
    .rd_data (rd_data),
    .fe_pend (fetch_req),
    .fe_byte (fetch_byte),
    .q       (regs),
    .mbr     (mbr)
  );

  // Registered outputs; strobe addresses use pre-write register values
  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr  <= '0;
      cbus_q     <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      fetch_req  <= 1'b0;
      fetch_addr <= '0;
    end else begin
      next_addr  <= f_next;
      cbus_q     <= cbus;
      rd_req     <= f_rd;
      rd_addr    <= regs[C_MAR];
      fetch_req  <= f_fe;
      fetch_addr <= regs[C_PC];
    end
  end

  // R2: next address follows the word of the previous cycle
  assert_next_follows_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (next_addr == $past(f_next)));

  // R9: the read bit of a word shows as a strobe one cycle later
  assert_read_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    f_rd |=> rd_req);

  // R11: a word without read or fetch bits raises neither strobe
  assert_no_stray_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    (!f_rd && !f_fe) |=> (!rd_req && !fetch_req));

endmodule

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;

  localparam int CLK_PERIOD = 10;

  // Field encodings as stated in the requirements
  localparam logic [1:0] A_H = 2'd0, A_Z = 2'd1, A_P1 = 2'd2, A_M1 = 2'd3;
  localparam logic [2:0] O_ADD = 3'd0, O_SUB = 3'd1, O_AND = 3'd2, O_OR = 3'd3,
                         O_PB = 3'd4, O_PA = 3'd5, O_ADD1 = 3'd6, O_NOTB = 3'd7;
  localparam logic [1:0] S_NO = 2'd0, S_L8 = 2'd1, S_R1 = 2'd2, S_X = 2'd3;
  localparam logic [2:0] M_NONE = 3'b000, M_FE = 3'b001, M_RD = 3'b010, M_WR = 3'b100;
  localparam logic [8:0] K_MAR = 9'h001, K_MDR = 9'h002, K_PC = 9'h004, K_SP = 9'h008,
                         K_LV = 9'h010, K_CPP = 9'h020, K_TOS = 9'h040, K_OPC = 9'h080,
                         K_H = 9'h100;
  localparam logic [3:0] Q_MDR = 4'd0, Q_PC = 4'd1, Q_MBS = 4'd2, Q_MBU = 4'd3, Q_SP = 4'd4,
                         Q_LV = 4'd5, Q_CPP = 4'd6, Q_TOS = 4'd7, Q_OPC = 4'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] uinstr = '0;
  logic [31:0] rd_data = '0;
  logic [7:0]  fetch_byte = '0;
  logic [8:0]  next_addr;
  logic [31:0] cbus_q, rd_addr, fetch_addr;
  logic        rd_req, fetch_req;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_datapath u_dut (
    .clk(clk), .rst(rst), .uinstr(uinstr), .rd_data(rd_data), .fetch_byte(fetch_byte),
    .next_addr(next_addr), .cbus_q(cbus_q), .rd_req(rd_req), .rd_addr(rd_addr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr)
  );

  function automatic logic [35:0] mk(input logic [8:0] na, input logic [2:0] jmp,
                                     input logic [1:0] sh, input logic [1:0] as,
                                     input logic [2:0] op, input logic [8:0] cm,
                                     input logic [2:0] mem, input logic [3:0] bs);
    return {na, jmp, sh, as, op, 1'b0, cm, mem, bs};
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic exec(input logic [35:0] w);
    uinstr = w;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Route a B source through the ALU unchanged and return it
  task automatic peek(input logic [3:0] bs, output logic [31:0] v);
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_NONE, bs));
    v = cbus_q;
  endtask

  task automatic peek_h(output logic [31:0] v);
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_PA, 9'h0, M_NONE, 4'd15));
    v = cbus_q;
  endtask

  // Bring a value in through a read, then copy MDR to the masked registers
  task automatic load(input logic [8:0] mask, input logic [31:0] v);
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_RD, 4'd15));
    rd_data = v;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_NONE, 4'd15));
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, mask, M_NONE, Q_MDR));
  endtask

  task automatic t_reset();
    check(32'(next_addr), 32'd0, "R1 next_addr");
    check(cbus_q, 32'd0, "R1 cbus_q");
    check(32'(rd_req), 32'd0, "R1 rd_req");
    check(32'(fetch_req), 32'd0, "R1 fetch_req");
    check(rd_addr, 32'd0, "R1 rd_addr");
    check(fetch_addr, 32'd0, "R1 fetch_addr");
  endtask

  task automatic t_next();
    exec(mk(9'd122, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_NONE, 4'd15));
    check(32'(next_addr), 32'd122, "R2 next address 122");
    exec(mk(9'd511, 3'd7, S_NO, A_Z, O_PB, 9'h0, M_NONE, 4'd15));
    check(32'(next_addr), 32'd511, "R2 jump bits ignored");
    check(32'(rd_req | fetch_req), 32'd0, "R2 jump bits raise nothing");
  endtask

  task automatic t_bsel();
    logic [31:0] v;
    load(K_PC, 32'h1111_0001);
    load(K_SP, 32'h2222_0002);
    load(K_LV, 32'h3333_0003);
    load(K_CPP, 32'h4444_0004);
    load(K_TOS, 32'h5555_0005);
    load(K_OPC, 32'h6666_0006);
    load(K_MDR, 32'h7777_0007);
    peek(Q_MDR, v); check(v, 32'h7777_0007, "R3 code 0 MDR");
    peek(Q_PC, v);  check(v, 32'h1111_0001, "R3 code 1 PC");
    peek(Q_SP, v);  check(v, 32'h2222_0002, "R3 code 4 SP");
    peek(Q_LV, v);  check(v, 32'h3333_0003, "R3 code 5 LV");
    peek(Q_CPP, v); check(v, 32'h4444_0004, "R3 code 6 CPP");
    peek(Q_TOS, v); check(v, 32'h5555_0005, "R3 code 7 TOS");
    peek(Q_OPC, v); check(v, 32'h6666_0006, "R3 code 8 OPC");
    for (int c = 9; c < 16; c++) begin
      peek(4'(c), v);
      check(v, 32'd0, $sformatf("R3 spare code %0d", c));
    end
  endtask

  task automatic t_mbr();
    logic [31:0] v;
    load(K_PC, 32'h0000_1234);
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, K_PC, M_FE, Q_TOS));
    check(32'(fetch_req), 32'd1, "R10 fetch strobe");
    check(fetch_addr, 32'h0000_1234, "R10 fetch address is PC before write");
    fetch_byte = 8'hF3;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_NONE, 4'd15));
    check(32'(fetch_req), 32'd0, "R10 strobe lasts one cycle");
    peek(Q_MBS, v); check(v, 32'hFFFF_FFF3, "R4 signed byte view");
    peek(Q_MBU, v); check(v, 32'h0000_00F3, "R4 unsigned byte view");
    peek(Q_PC, v);  check(v, 32'h5555_0005, "R10 PC written by same word");
  endtask

  task automatic t_aside();
    logic [31:0] v;
    load(K_H, 32'd6);
    load(K_SP, 32'h13);
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_ADD, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h13, "R5 A zero");
    exec(mk(9'd0, 3'd0, S_NO, A_P1, O_ADD, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h14, "R5 A plus one");
    exec(mk(9'd0, 3'd0, S_NO, A_M1, O_ADD, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h12, "R5 A minus one");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_ADD, K_MDR, M_NONE, Q_SP));
    check(cbus_q, 32'h19, "R5 A is H (H+SP)");
    peek(Q_MDR, v); check(v, 32'h19, "R8 MDR took H+SP");
  endtask

  task automatic t_ops();
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_SUB, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h0D, "R6 B-A");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_AND, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h02, "R6 AND");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_OR, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h17, "R6 OR");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_PA, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h06, "R6 pass A");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_ADD1, 9'h0, M_NONE, Q_SP));
    check(cbus_q, 32'h1A, "R6 A+B+1");
    exec(mk(9'd0, 3'd0, S_NO, A_H, O_NOTB, 9'h0, M_NONE, Q_SP));
    check(cbus_q, ~32'h13, "R6 NOT B");
  endtask

  task automatic t_shift();
    load(K_TOS, 32'h8000_0010);
    exec(mk(9'd0, 3'd0, S_L8, A_Z, O_PB, 9'h0, M_NONE, Q_TOS));
    check(cbus_q, 32'h0000_1000, "R7 left by 8");
    exec(mk(9'd0, 3'd0, S_R1, A_Z, O_PB, 9'h0, M_NONE, Q_TOS));
    check(cbus_q, 32'hC000_0008, "R7 arithmetic right by 1");
    exec(mk(9'd0, 3'd0, S_X, A_Z, O_PB, 9'h0, M_NONE, Q_TOS));
    check(cbus_q, 32'h8000_0010, "R7 code 3 unshifted");
  endtask

  task automatic t_multi();
    logic [31:0] v;
    exec(mk(9'd0, 3'd0, S_NO, A_P1, O_ADD, K_LV | K_CPP | K_OPC, M_NONE, Q_TOS));
    peek(Q_LV, v);  check(v, 32'h8000_0011, "R8 LV in multi-write");
    peek(Q_CPP, v); check(v, 32'h8000_0011, "R8 CPP in multi-write");
    peek(Q_OPC, v); check(v, 32'h8000_0011, "R8 OPC in multi-write");
    peek(Q_SP, v);  check(v, 32'h13, "R8 SP untouched");
    peek_h(v);      check(v, 32'd6, "R8 H untouched");
  endtask

  task automatic t_read();
    logic [31:0] v;
    load(K_MAR, 32'h40);
    exec(mk(9'd0, 3'd0, S_NO, A_P1, O_ADD, K_SP | K_MAR, M_RD, Q_SP));
    check(32'(rd_req), 32'd1, "R9 read strobe");
    check(rd_addr, 32'h40, "R9 address is MAR before write");
    check(cbus_q, 32'h14, "R9 SP=SP+1 alongside read");
    rd_data = 32'hAAAA_5555;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, K_MDR, M_RD, Q_SP));
    check(rd_addr, 32'h14, "R9 address follows new MAR");
    rd_data = 32'hBEEF_0001;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_NONE, 4'd15));
    peek(Q_MDR, v); check(v, 32'hBEEF_0001, "R9 second read loaded MDR");
    rd_data = 32'hAAAA_5555;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_RD, 4'd15));
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, K_MDR, M_NONE, Q_SP));
    check(32'(rd_req), 32'd0, "R9 strobe lasts one cycle");
    peek(Q_MDR, v); check(v, 32'hAAAA_5555, "R9 read beats C bus into MDR");
  endtask

  task automatic t_write();
    logic [31:0] v;
    exec(mk(9'd0, 3'd0, S_NO, A_Z, O_PB, 9'h0, M_WR, Q_SP));
    check(32'(rd_req | fetch_req), 32'd0, "R11 write bit raises no strobe");
    peek(Q_SP, v);  check(v, 32'h14, "R11 SP unchanged");
    peek(Q_MDR, v); check(v, 32'hAAAA_5555, "R11 MDR unchanged");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_next();
    t_bsel();
    t_mbr();
    t_aside();
    t_ops();
    t_shift();
    t_multi();
    t_read();
    t_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule